// File: doc/BRIEF.md
# Compare-Match Port Output Controller

This block watches a running count supplied from outside and compares it against three programmable compare values on every clock. A comparator fires on the single cycle in which the count first becomes equal to its value. The three comparators drive an 8-bit output port. The first comparator drives the six low bits high. The second drives them low. The third inverts the two high bits. A per-bit enable decides which bits each action may touch.

Every comparator event also latches an interrupt flag, and only software clears it. Software reaches the compare values, the port, the two enable registers and the flags through a byte-wide register interface with one write port and one combinational read port. A compare value is written as two bytes. The low byte waits in a staging register, and the whole value becomes active when the high byte is written. Software may write the port at any time. In a cycle where that write meets a comparator event, the hardware action wins on the bits it is enabled for.

Top module: `cmp_port_ctrl`

## Requirements
- R1: Each comparator produces one event on the cycle in which `count_i` first equals its active value. The port and flag effects are visible after the clock edge that ends that cycle. No further event is produced while the equality holds.
- R2: Compare k has its low byte at address 2k and its high byte at address 2k+1, for k = 0, 1, 2. A low-byte write is only staged. A high-byte write loads {written byte, staged byte} as the active value. Reads at these addresses return the active value's bytes.
- R3: An event on compare 0 drives to 1 every port bit 0..5 whose bit is set in the set-enable register (address 7, bits 0..5).
- R4: An event on compare 1 drives to 0 every port bit 0..5 whose bit is set in the reset/toggle-enable register (address 8, bits 0..5).
- R5: When compare 0 and compare 1 fire in the same cycle, the clear takes priority on every bit that is reset-enabled. A bit that is enabled only for set is still driven to 1.
- R6: An event on compare 2 inverts each of port bits 6 and 7 whose bit is set in the reset/toggle-enable register (address 8, bits 6..7).
- R7: A software write to the port (address 6) loads the written byte. If a comparator event occurs in the same cycle, the bits touched by that event take the hardware result and the remaining bits take the written value. With no write and no event, the port holds its value.
- R8: An event on compare k sets flag k, which is visible on `irq_o[k]` and at address 9 bit k. Writing 1 to bit k of address 9 clears flag k. A flag that is set by an event in the same cycle as a clear stays set.
- R9: Reset clears the active and staged compare values, the port, both enable registers and all flags.
- R10: The read port returns, without side effects: the port at address 6, the set-enable register in bits 5..0 at address 7 (upper bits 0), the reset/toggle-enable register at address 8, the flags in bits 2..0 at address 9, and 0 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| count_i | input | CNT_W | Running count compared against the three compare values |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| port_o | output | 8 | Output port driven by the compare events |
| irq_o | output | 3 | Interrupt flags, one per comparator |

## Verification
The bench builds the block with the default CNT_W of 16. It drives `count_i` directly instead of through a counter, so values such as 0x4000 and 0x1234 can be placed in a single cycle. This makes simultaneous events, an event coinciding with a port write, and an event coinciding with a flag clear easy to line up. A randomized phase restricts the count and the compare values to 0..7. Repeated hits, re-arming after the equality drops, and reprogramming a value to the current count then occur many times and are checked against the reference model.

// File: rtl/cmp_port_pkg.sv
package cmp_port_pkg;
  localparam int PORT_W = 8;
  localparam int SET_W  = 6;
  localparam int TGL_W  = PORT_W - SET_W;
  localparam int NCMP   = 3;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] A_PORT  = 4'd6;
  localparam logic [ADDR_W-1:0] A_SETEN = 4'd7;
  localparam logic [ADDR_W-1:0] A_RTEN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_FLAG  = 4'd9;

  // Next port value: software write forms the base, hardware actions own
  // their enabled bits; clear beats set, toggle inverts the present value.
  function automatic logic [PORT_W-1:0] port_next(
    input logic [PORT_W-1:0] cur,
    input logic              sw_wr,
    input logic [PORT_W-1:0] sw_val,
    input logic              hit_set,
    input logic              hit_clr,
    input logic              hit_tgl,
    input logic [PORT_W-1:0] set_en,
    input logic [PORT_W-1:0] rt_en
  );
    logic [PORT_W-1:0] base, set_m, clr_m, tgl_m, hw_m;
    base  = sw_wr ? sw_val : cur;
    set_m = hit_set ? {{TGL_W{1'b0}}, set_en[SET_W-1:0]} : '0;
    clr_m = hit_clr ? {{TGL_W{1'b0}}, rt_en[SET_W-1:0]} : '0;
    tgl_m = hit_tgl ? {rt_en[PORT_W-1:SET_W], {SET_W{1'b0}}} : '0;
    hw_m  = set_m | clr_m | tgl_m;
    return (base & ~hw_m) | (set_m & ~clr_m) | (tgl_m & ~cur);
  endfunction

  // Flag update: software clear mask first, new events on top.
  function automatic logic [NCMP-1:0] flag_next(
    input logic [NCMP-1:0] cur,
    input logic            clr_wr,
    input logic [NCMP-1:0] clr_mask,
    input logic [NCMP-1:0] hits
  );
    logic [NCMP-1:0] kept;
    kept = clr_wr ? (cur & ~clr_mask) : cur;
    return kept | hits;
  endfunction
endpackage

// File: rtl/cmp_unit.sv
module cmp_unit #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             wr_lo_i,
  input  logic             wr_hi_i,
  input  logic [7:0]       wdata_i,
  output logic [CNT_W-1:0] value_o,
  output logic             match_o
);
  localparam int HI_W = CNT_W - 8;

  logic [7:0]       stage_q;
  logic [CNT_W-1:0] cmp_q;
  logic             eq_now;
  logic             eq_q;

  assign eq_now  = (cnt_i == cmp_q);
  assign match_o = eq_now && !eq_q;
  assign value_o = cmp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= '0;
      cmp_q   <= '0;
      eq_q    <= 1'b0;
    end else begin
      eq_q <= eq_now;
      if (wr_lo_i) stage_q <= wdata_i;
      if (wr_hi_i) cmp_q   <= {wdata_i[HI_W-1:0], stage_q};
    end
  end

  // R1
  single_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |=> !match_o);

  // R1
  match_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_o |-> (cnt_i == value_o));

  // R2
  value_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_hi_i |=> $stable(value_o));
endmodule

// File: rtl/port_unit.sv
module port_unit
  import cmp_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sw_wr_i,
  input  logic [PORT_W-1:0] sw_val_i,
  input  logic [NCMP-1:0]   hit_i,
  input  logic [PORT_W-1:0] set_en_i,
  input  logic [PORT_W-1:0] rt_en_i,
  output logic [PORT_W-1:0] port_o
);
  logic [PORT_W-1:0] port_q;
  logic [PORT_W-1:0] port_d;

  assign port_d = port_next(port_q, sw_wr_i, sw_val_i, hit_i[0], hit_i[1],
                            hit_i[2], set_en_i, rt_en_i);
  assign port_o = port_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) port_q <= '0;
    else        port_q <= port_d;
  end

  // R3
  set_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i[0] && !hit_i[1]) |=>
      ((port_q[SET_W-1:0] & $past(set_en_i[SET_W-1:0])) == $past(set_en_i[SET_W-1:0])));

  // R4
  clr_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i[1] |=> ((port_q[SET_W-1:0] & $past(rt_en_i[SET_W-1:0])) == '0));

  // R5
  set_only_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i[0] && hit_i[1]) |=>
      ((port_q[SET_W-1:0] & $past(set_en_i[SET_W-1:0] & ~rt_en_i[SET_W-1:0]))
        == $past(set_en_i[SET_W-1:0] & ~rt_en_i[SET_W-1:0])));

  // R6
  toggle_action_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i[2] |=>
      ((port_q[PORT_W-1:SET_W] & $past(rt_en_i[PORT_W-1:SET_W]))
        == (~$past(port_q[PORT_W-1:SET_W]) & $past(rt_en_i[PORT_W-1:SET_W]))));

  // R7
  sw_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr_i && hit_i == '0) |=> (port_q == $past(sw_val_i)));

  // R7
  port_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sw_wr_i && hit_i == '0) |=> $stable(port_q));
endmodule

// File: rtl/irq_unit.sv
module irq_unit
  import cmp_port_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NCMP-1:0] hit_i,
  input  logic            clr_wr_i,
  input  logic [NCMP-1:0] clr_mask_i,
  output logic [NCMP-1:0] flag_o
);
  logic [NCMP-1:0] flag_q;

  assign flag_o = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= flag_next(flag_q, clr_wr_i, clr_mask_i, hit_i);
  end

  // R8
  flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit_i != '0) |=> ((flag_q & $past(hit_i)) == $past(hit_i)));

  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr_i |=> ((flag_q & $past(flag_q)) == $past(flag_q)));
endmodule

// File: rtl/cmp_port_ctrl.sv
module cmp_port_ctrl
  import cmp_port_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  count_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic [PORT_W-1:0] port_o,
  output logic [NCMP-1:0]   irq_o
);
  logic [NCMP-1:0]   hit;
  logic [CNT_W-1:0]  cmp_val [NCMP];
  logic [SET_W-1:0]  set_en_q;
  logic [PORT_W-1:0] rt_en_q;
  logic [PORT_W-1:0] port_q;
  logic [NCMP-1:0]   flag_q;
  logic              port_wr;
  logic              flag_wr;

  assign port_wr = wr_en_i && (wr_addr_i == A_PORT);
  assign flag_wr = wr_en_i && (wr_addr_i == A_FLAG);

  for (genvar k = 0; k < NCMP; k++) begin : g_cmp
    logic wr_lo;
    logic wr_hi;
    assign wr_lo = wr_en_i && (wr_addr_i == ADDR_W'(2 * k));
    assign wr_hi = wr_en_i && (wr_addr_i == ADDR_W'(2 * k + 1));
    cmp_unit #(.CNT_W(CNT_W)) u_cmp (
      .clk     (clk),
      .rst_n   (rst_n),
      .cnt_i   (count_i),
      .wr_lo_i (wr_lo),
      .wr_hi_i (wr_hi),
      .wdata_i (wr_data_i),
      .value_o (cmp_val[k]),
      .match_o (hit[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      set_en_q <= '0;
      rt_en_q  <= '0;
    end else if (wr_en_i) begin
      if (wr_addr_i == A_SETEN) set_en_q <= wr_data_i[SET_W-1:0];
      if (wr_addr_i == A_RTEN)  rt_en_q  <= wr_data_i[PORT_W-1:0];
    end
  end

  port_unit u_port (
    .clk      (clk),
    .rst_n    (rst_n),
    .sw_wr_i  (port_wr),
    .sw_val_i (wr_data_i[PORT_W-1:0]),
    .hit_i    (hit),
    .set_en_i ({{TGL_W{1'b0}}, set_en_q}),
    .rt_en_i  (rt_en_q),
    .port_o   (port_q)
  );

  irq_unit u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .hit_i      (hit),
    .clr_wr_i   (flag_wr),
    .clr_mask_i (wr_data_i[NCMP-1:0]),
    .flag_o     (flag_q)
  );

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      A_PORT:  rd_data_o = DATA_W'(port_q);
      A_SETEN: rd_data_o = DATA_W'(set_en_q);
      A_RTEN:  rd_data_o = DATA_W'(rt_en_q);
      A_FLAG:  rd_data_o = DATA_W'(flag_q);
      default: rd_data_o = '0;
    endcase
    for (int k = 0; k < NCMP; k++) begin
      if (rd_addr_i == ADDR_W'(2 * k))     rd_data_o = cmp_val[k][7:0];
      if (rd_addr_i == ADDR_W'(2 * k + 1)) rd_data_o = DATA_W'(cmp_val[k][CNT_W-1:8]);
    end
  end

  assign port_o = port_q;
  assign irq_o  = flag_q;

  // R9
  reset_state_chk: assert property (@(posedge clk)
    !rst_n |-> (port_q == '0 && flag_q == '0 && set_en_q == '0 && rt_en_q == '0));

  // R8
  irq_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> (irq_o != '0));
endmodule

// File: tb/cmp_port_ctrl_test.sv
module cmp_port_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] count_i = 16'h1234;
  logic        wr_en_i = 1'b0;
  logic [3:0]  wr_addr_i = '0;
  logic [7:0]  wr_data_i = '0;
  logic [3:0]  rd_addr_i = '0;
  logic [7:0]  rd_data_o;
  logic [7:0]  port_o;
  logic [2:0]  irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  cmp_port_ctrl #(.CNT_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .count_i(count_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_addr_i(rd_addr_i),
    .rd_data_o(rd_data_o), .port_o(port_o), .irq_o(irq_o)
  );

  always #5 clk = ~clk;

  // ---------------- reference model ----------------
  int       m_cmp [3];
  int       m_stage [3];
  bit       m_prev [3];
  bit [7:0] m_port;
  bit [7:0] m_ste;
  bit [7:0] m_rte;
  bit [2:0] m_flag;
  bit [2:0] mh;
  bit [7:0] np;
  bit [2:0] nf;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) begin
        m_cmp[k] = 0; m_stage[k] = 0; m_prev[k] = 0;
      end
      m_port = 0; m_ste = 0; m_rte = 0; m_flag = 0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        mh[k] = (int'(count_i) == m_cmp[k]) && !m_prev[k];
        m_prev[k] = (int'(count_i) == m_cmp[k]);
      end
      np = (wr_en_i && wr_addr_i == 4'd6) ? wr_data_i : m_port;
      for (int b = 0; b < 6; b++) begin
        if (mh[1] && m_rte[b])      np[b] = 1'b0;
        else if (mh[0] && m_ste[b]) np[b] = 1'b1;
      end
      for (int b = 6; b < 8; b++)
        if (mh[2] && m_rte[b]) np[b] = ~m_port[b];
      nf = m_flag;
      if (wr_en_i && wr_addr_i == 4'd9) nf = nf & ~wr_data_i[2:0];
      nf = nf | mh;
      if (wr_en_i) begin
        case (wr_addr_i)
          4'd0, 4'd2, 4'd4: m_stage[wr_addr_i / 2] = wr_data_i;
          4'd1, 4'd3, 4'd5: m_cmp[wr_addr_i / 2] = wr_data_i * 256 + m_stage[wr_addr_i / 2];
          4'd7: m_ste = wr_data_i & 8'h3F;
          4'd8: m_rte = wr_data_i;
          default: ;
        endcase
      end
      m_port = np;
      m_flag = nf;
    end
  end

  function automatic int mread(input logic [3:0] a);
    case (a)
      4'd0, 4'd2, 4'd4: return m_cmp[a / 2] % 256;
      4'd1, 4'd3, 4'd5: return m_cmp[a / 2] / 256;
      4'd6: return m_port;
      4'd7: return m_ste;
      4'd8: return m_rte;
      4'd9: return m_flag;
      default: return 0;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison with the model, away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      check("R3 R4 R5 R6 R7 port vs model", port_o, m_port);
      check("R8 flags vs model", irq_o, m_flag);
      check("R2 R10 read vs model", rd_data_o, mread(rd_addr_i));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic wr(input int a, input int d);
    wr_en_i = 1'b1; wr_addr_i = 4'(a); wr_data_i = 8'(d);
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    #1;
  endtask

  task automatic rdchk(input string req, input int a, input int exp);
    rd_addr_i = 4'(a);
    #1;
    check(req, rd_data_o, exp);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    // R9 reset state
    check("R9 port after reset", port_o, 0);
    check("R9 irq after reset", irq_o, 0);
    rdchk("R9 cmp0 hi after reset", 1, 0);
    rdchk("R9 cmp2 lo after reset", 4, 0);
    rdchk("R9 rt-enable after reset", 8, 0);

    wr(7, 8'h3F);
    wr(8, 8'hFF);
    // R2 staging: low byte alone does not change the active value
    wr(0, 8'h00);
    wr(0, 8'h00);
    rdchk("R2 cmp0 hi before high write", 1, 0);
    wr(1, 8'h01);
    rdchk("R2 cmp0 hi after high write", 1, 8'h01);
    // R3 set
    count_i = 16'h0100;
    tick();
    check("R3 set bits 0..5", port_o, 8'h3F);
    check("R8 flag0 set", irq_o, 3'b001);
    // R1 single event while equality holds
    wr(9, 8'h01);
    tick(); tick(); tick();
    check("R1 no refire while equal", irq_o, 0);
    // R2 staged low byte of cmp1 not yet active
    wr(2, 8'h34);
    count_i = 16'h0034;
    tick();
    check("R2 staged byte inactive", port_o, 8'h3F);
    wr(3, 8'h12);
    count_i = 16'h1234;
    tick();
    check("R4 clear bits 0..5", port_o, 8'h00);
    check("R8 flag1 set", irq_o, 3'b010);
    // R5 simultaneous set and clear
    wr(9, 8'h07);
    wr(0, 8'h00); wr(1, 8'h20);
    wr(2, 8'h00); wr(3, 8'h20);
    wr(8, 8'h0F);
    count_i = 16'h2000;
    tick();
    check("R5 clear wins, set-only bits set", port_o, 8'h30);
    check("R8 two flags", irq_o, 3'b011);
    // R6 toggle
    wr(9, 8'h07);
    wr(4, 8'h00); wr(5, 8'h30);
    wr(8, 8'h40);
    count_i = 16'h3000;
    tick();
    check("R6 toggle bit 6 on", port_o, 8'h70);
    count_i = 16'h0005;
    tick();
    count_i = 16'h3000;
    tick();
    check("R6 toggle bit 6 off", port_o, 8'h30);
    // R7 software write, then write coinciding with an event
    wr(6, 8'h81);
    #1;
    check("R7 software write", port_o, 8'h81);
    wr(8, 8'hFF);
    wr(0, 8'h00); wr(1, 8'h40);
    count_i = 16'h4000;
    wr(6, 8'h80);
    #1;
    check("R7 write merged with set", port_o, 8'hBF);
    // R8 set beats clear in the same cycle
    wr(9, 8'h07);
    count_i = 16'h0005;
    tick();
    count_i = 16'h3000;
    wr(9, 8'h04);
    #1;
    check("R8 set wins over clear", irq_o, 3'b100);
    check("R6 both high bits toggle", port_o, 8'h7F);
    // R10 reads
    rdchk("R10 read port", 6, 8'h7F);
    rdchk("R10 read set-enable", 7, 8'h3F);
    rdchk("R10 read flags", 9, 8'h04);
    rdchk("R10 unmapped address", 12, 0);
    check("R10 read has no side effect", port_o, 8'h7F);

    // randomized phase against the model
    for (int i = 0; i < 600; i++) begin
      int a;
      count_i   = 16'($urandom_range(0, 7));
      rd_addr_i = 4'($urandom_range(0, 10));
      if ($urandom_range(0, 2) == 0) begin
        a = $urandom_range(0, 9);
        if (a < 6) wr(a, (a % 2 == 1) ? 0 : $urandom_range(0, 7));
        else       wr(a, $urandom_range(0, 255));
      end else begin
        @(negedge clk);
      end
    end

    // R9 reset mid-run
    rst_n = 1'b0;
    count_i = 16'h1234;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    tick();
    check("R9 port after second reset", port_o, 0);
    check("R9 irq after second reset", irq_o, 0);
    rdchk("R9 cmp1 lo after second reset", 2, 0);
    rdchk("R9 set-enable after second reset", 7, 0);
    tick();
    finish_run();
  end
endmodule